// File: doc/BRIEF.md
# Row-Multiplexed LED Matrix Scanner with Dimming

This block scans a character RAM of four characters, each seven rows by five columns, onto a row-multiplexed LED matrix. One row is lit at a time: a one-hot row strobe selects the row, and twenty column outputs carry that row's bits for all four characters side by side. Timing comes from a multiplex clock enable. Each enable pulse, or every sixteenth pulse when the prescaler is switched on, advances a slot counter of 64 ticks per row. After 64 slots the row counter steps to the next row. A full frame is 448 slots.

Brightness is set by how long each row stays lit within its 64-slot window. A 3-bit level picks one of eight on-counts, and a peak-reduction flag divides that on-count by eight. The top level code blanks the display and raises a power-down flag. The first slot of every row is always dark, so no column data lingers across a row change. The outputs are registered and change only when the slot counter advances. The block presents the current row index to the RAM and reads back that row's 20 bits in the same cycle.

Top module: `rowscan_dimmer`

## Requirements
- R1: While `rst_n` is low, `row_strobe`, `col_drive`, `power_down` and `ram_row` are all zero, and the prescaler, slot and row counters are cleared. The reset acts at once, without waiting for a clock edge.
- R2: With `prescale_en` low, every cycle with `mux_tick` high advances the slot counter by one. The slot counter runs from 0 to 63. On the advance out of slot 63, `ram_row` steps by one through rows 0 to 6 and then wraps to 0, so a frame is 448 advances.
- R3: With `prescale_en` high, only every sixteenth `mux_tick` advances the slot counter. The prescale count restarts at zero whenever `prescale_en` is low, so the first advance after enabling comes on the sixteenth tick.
- R4: `row_strobe` and `col_drive` change only in cycles with an advance. After an advance, they show the slot position the scanner held just before that advance.
- R5: At most one bit of `row_strobe` is high. When a position in row r is lit, bit r of `row_strobe` is high.
- R6: When a position is lit, `col_drive` bit c*5+k equals `ram_rdata` bit c*5+k, which is column k of character c for row `ram_row`. When the position is dark, `col_drive` is zero.
- R7: Slot 0 of every row is dark, whatever the level.
- R8: For level L, a position with slot s is lit when 1 <= s < N(L). N for levels 0 to 7 is 64, 34, 26, 17, 13, 8, 4, 0.
- R9: With `peak_reduce` high, N(L) is replaced by floor(N(L)/8), which gives 8, 4, 3, 2, 1, 1, 0, 0.
- R10: Level 7 keeps every output dark. `power_down` equals (level == 7) as registered on the previous clock.
- R11: Asserting `rst_n` in the middle of a scan brings the next frame back to row 0, slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_tick | input | 1 | Multiplex clock enable, one pulse per multiplex tick |
| prescale_en | input | 1 | Divide the multiplex ticks by 16 |
| peak_reduce | input | 1 | Scale the on-count down to one eighth |
| level | input | 3 | Brightness level, 7 = blank and power-down |
| ram_rdata | input | 20 | Column bits of row `ram_row` for all characters |
| ram_row | output | 3 | Row index presented to the RAM |
| row_strobe | output | 7 | One-hot row drive |
| col_drive | output | 20 | Column drive, character c column k at bit c*5+k |
| power_down | output | 1 | High while level 7 is selected |

## Verification
The bench builds the block with its default parameters: 4 characters, 7 rows, 5 columns, 64 slots per row and a divide-by-16 prescaler. With these values, one frame takes 448 cycles when a tick arrives every cycle, so every level can be swept in both peak modes, each over a whole frame, and the lit-slot count of a row can be measured directly. The prescaled path needs 1024 ticks for a single row step. That step is within reach, as are tick patterns with gaps, data changes in the middle of a frame, and a reset part-way through a scan.

// File: rtl/rowscan_pkg.sv
package rowscan_pkg;

  localparam int unsigned LEVEL_W = 3;
  typedef logic [LEVEL_W-1:0] level_t;
  localparam level_t LEVEL_OFF = 3'd7;

  // On-count for one row window, in slot ticks, before any blanking of slot 0.
  // The eight steps are defined in 64ths of the window and scaled to slot_ticks.
  function automatic int unsigned on_ticks(int unsigned slot_ticks, level_t lvl,
                                           logic reduce, int unsigned shift);
    int unsigned k64;
    int unsigned n;
    case (lvl)
      3'd0:    k64 = 64;
      3'd1:    k64 = 34;
      3'd2:    k64 = 26;
      3'd3:    k64 = 17;
      3'd4:    k64 = 13;
      3'd5:    k64 = 8;
      3'd6:    k64 = 4;
      default: k64 = 0;
    endcase
    n = (slot_ticks * k64) / 64;
    if (reduce) n = n >> shift;
    return n;
  endfunction

endpackage

// File: rtl/rowscan_prescale.sv
module rowscan_prescale #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic enable_i,
  output logic adv_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign adv_o = tick_i && (!enable_i || (cnt_q == LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!enable_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rowscan_timebase.sv
module rowscan_timebase #(
  parameter int unsigned SLOT_TICKS = 64,
  parameter int unsigned NUM_ROWS   = 7,
  localparam int unsigned SLOT_W    = $clog2(SLOT_TICKS),
  localparam int unsigned ROW_W     = $clog2(NUM_ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [ROW_W-1:0]  row_o
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_TICKS - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(NUM_ROWS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [ROW_W-1:0]  row_q;
  logic              slot_wrap;

  assign slot_wrap = (slot_q == SLOT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      row_q  <= '0;
    end else if (adv_i) begin
      slot_q <= slot_wrap ? '0 : slot_q + 1'b1;
      if (slot_wrap) begin
        row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
      end
    end
  end

  assign slot_o = slot_q;
  assign row_o  = row_q;
endmodule

// File: rtl/rowscan_window.sv
module rowscan_window
  import rowscan_pkg::*;
#(
  parameter int unsigned SLOT_TICKS = 64,
  parameter int unsigned PEAK_SHIFT = 3,
  localparam int unsigned SLOT_W    = $clog2(SLOT_TICKS)
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  level_t            level_i,
  input  logic              reduce_i,
  output logic              lit_o
);
  int unsigned limit;

  always_comb begin
    limit = on_ticks(SLOT_TICKS, level_i, reduce_i, PEAK_SHIFT);
    lit_o = (level_i != LEVEL_OFF) && (slot_i != '0) && (32'(slot_i) < limit);
  end
endmodule

// File: rtl/rowscan_outreg.sv
module rowscan_outreg
  import rowscan_pkg::*;
#(
  parameter int unsigned NUM_CHARS = 4,
  parameter int unsigned NUM_ROWS  = 7,
  parameter int unsigned NUM_COLS  = 5,
  localparam int unsigned ROW_W    = $clog2(NUM_ROWS),
  localparam int unsigned COLS_ALL = NUM_CHARS * NUM_COLS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv_i,
  input  logic                lit_i,
  input  logic [ROW_W-1:0]    row_i,
  input  logic [COLS_ALL-1:0] rdata_i,
  input  level_t              level_i,
  output logic [NUM_ROWS-1:0] strobe_o,
  output logic [COLS_ALL-1:0] cols_o,
  output logic                pd_o
);
  logic [NUM_ROWS-1:0] strobe_d;
  logic [COLS_ALL-1:0] cols_d;
  logic [NUM_ROWS-1:0] strobe_q;
  logic [COLS_ALL-1:0] cols_q;
  logic                pd_q;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign strobe_d[r] = lit_i && (row_i == ROW_W'(r));
  end

  for (genvar c = 0; c < NUM_CHARS; c++) begin : g_char
    assign cols_d[c*NUM_COLS +: NUM_COLS] =
      lit_i ? rdata_i[c*NUM_COLS +: NUM_COLS] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= '0;
      cols_q   <= '0;
    end else if (adv_i) begin
      strobe_q <= strobe_d;
      cols_q   <= cols_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_q <= 1'b0;
    else        pd_q <= (level_i == LEVEL_OFF);
  end

  assign strobe_o = strobe_q;
  assign cols_o   = cols_q;
  assign pd_o     = pd_q;
endmodule

// File: rtl/rowscan_dimmer.sv
module rowscan_dimmer
  import rowscan_pkg::*;
#(
  parameter int unsigned NUM_CHARS    = 4,
  parameter int unsigned NUM_ROWS     = 7,
  parameter int unsigned NUM_COLS     = 5,
  parameter int unsigned SLOT_TICKS   = 64,
  parameter int unsigned PRESCALE_DIV = 16,
  parameter int unsigned PEAK_SHIFT   = 3,
  localparam int unsigned ROW_W       = $clog2(NUM_ROWS),
  localparam int unsigned SLOT_W      = $clog2(SLOT_TICKS),
  localparam int unsigned COLS_ALL    = NUM_CHARS * NUM_COLS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mux_tick,
  input  logic                prescale_en,
  input  logic                peak_reduce,
  input  logic [2:0]          level,
  input  logic [COLS_ALL-1:0] ram_rdata,
  output logic [ROW_W-1:0]    ram_row,
  output logic [NUM_ROWS-1:0] row_strobe,
  output logic [COLS_ALL-1:0] col_drive,
  output logic                power_down
);
  // Named internal events, also visible to the bound checker.
  logic              slot_adv;
  logic [SLOT_W-1:0] slot_q;
  logic [ROW_W-1:0]  row_q;
  logic              pos_lit;

  rowscan_prescale #(.DIV(PRESCALE_DIV)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (mux_tick),
    .enable_i (prescale_en),
    .adv_o    (slot_adv)
  );

  rowscan_timebase #(.SLOT_TICKS(SLOT_TICKS), .NUM_ROWS(NUM_ROWS)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (slot_adv),
    .slot_o (slot_q),
    .row_o  (row_q)
  );

  rowscan_window #(.SLOT_TICKS(SLOT_TICKS), .PEAK_SHIFT(PEAK_SHIFT)) u_win (
    .slot_i   (slot_q),
    .level_i  (level),
    .reduce_i (peak_reduce),
    .lit_o    (pos_lit)
  );

  rowscan_outreg #(.NUM_CHARS(NUM_CHARS), .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (slot_adv),
    .lit_i    (pos_lit),
    .row_i    (row_q),
    .rdata_i  (ram_rdata),
    .level_i  (level),
    .strobe_o (row_strobe),
    .cols_o   (col_drive),
    .pd_o     (power_down)
  );

  assign ram_row = row_q;
endmodule

// File: rtl/rowscan_dimmer_chk.sv
module rowscan_dimmer_chk #(
  parameter int unsigned NUM_ROWS   = 7,
  parameter int unsigned SLOT_TICKS = 64,
  parameter int unsigned COLS_ALL   = 20,
  localparam int unsigned ROW_W     = $clog2(NUM_ROWS),
  localparam int unsigned SLOT_W    = $clog2(SLOT_TICKS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mux_tick,
  input logic [2:0]          level,
  input logic                slot_adv,
  input logic [SLOT_W-1:0]   slot_q,
  input logic [ROW_W-1:0]    row_q,
  input logic [NUM_ROWS-1:0] row_strobe,
  input logic [COLS_ALL-1:0] col_drive,
  input logic                power_down
);
  a_r2_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_adv && slot_q == SLOT_W'(SLOT_TICKS - 1)) |=>
      (row_q == (($past(row_q) == ROW_W'(NUM_ROWS - 1)) ? '0 : $past(row_q) + 1'b1)));

  a_r3_adv_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    slot_adv |-> mux_tick);

  a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_adv |=> ($stable(row_strobe) && $stable(col_drive)));

  a_r5_single_row: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_strobe));

  a_r6_dark_cols: assert property (@(posedge clk) disable iff (!rst_n)
    (row_strobe == '0) |-> (col_drive == '0));

  a_r7_first_slot_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_adv && slot_q == '0) |=> (row_strobe == '0));

  a_r10_off_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_adv && level == 3'd7) |=> (row_strobe == '0 && col_drive == '0));

  a_r10_pd_flag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (power_down == ($past(level) == 3'd7)));
endmodule

bind rowscan_dimmer rowscan_dimmer_chk #(
  .NUM_ROWS   (NUM_ROWS),
  .SLOT_TICKS (SLOT_TICKS),
  .COLS_ALL   (COLS_ALL)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mux_tick   (mux_tick),
  .level      (level),
  .slot_adv   (slot_adv),
  .slot_q     (slot_q),
  .row_q      (row_q),
  .row_strobe (row_strobe),
  .col_drive  (col_drive),
  .power_down (power_down)
);

// File: tb/rowscan_dimmer_tb_top.sv
module rowscan_dimmer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mux_tick = 1'b0;
  logic        prescale_en = 1'b0;
  logic        peak_reduce = 1'b0;
  logic [2:0]  level = 3'd0;
  logic [19:0] ram_rdata;
  logic [2:0]  ram_row;
  logic [6:0]  row_strobe;
  logic [19:0] col_drive;
  logic        power_down;

  logic [19:0] mem [0:6];
  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  assign ram_rdata = (ram_row < 3'd7) ? mem[ram_row] : 20'h0;

  rowscan_dimmer dut_i (
    .clk(clk), .rst_n(rst_n), .mux_tick(mux_tick), .prescale_en(prescale_en),
    .peak_reduce(peak_reduce), .level(level), .ram_rdata(ram_rdata),
    .ram_row(ram_row), .row_strobe(row_strobe), .col_drive(col_drive),
    .power_down(power_down)
  );

  // Brightness reference: lit slots come from a list of on-counts per level.
  int on_list [8] = '{64, 34, 26, 17, 13, 8, 4, 0};

  function automatic int ref_limit(int lvl, bit red);
    int n = on_list[lvl];
    return red ? n / 8 : n;
  endfunction

  // Behavioural reference model: position in frame as a plain integer.
  int          m_pre, m_pos;
  logic [6:0]  e_row;
  logic [19:0] e_col;
  logic        e_pd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_pos = 0; e_row = '0; e_col = '0; e_pd = 1'b0;
    end else begin
      bit adv;
      int s, r;
      bit lit;
      adv = mux_tick && (!prescale_en || m_pre == 15);
      if (!prescale_en) m_pre = 0;
      else if (mux_tick) m_pre = (m_pre + 1) % 16;
      e_pd = (level == 3'd7);
      if (adv) begin
        s = m_pos % 64;
        r = m_pos / 64;
        lit = (level != 3'd7) && (s >= 1) && (s < ref_limit(int'(level), peak_reduce));
        e_row = lit ? 7'(1 << r) : 7'h0;
        e_col = lit ? mem[r] : 20'h0;
        m_pos = (m_pos + 1) % 448;
      end
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check(row_strobe == e_row, "R4/R5/R8 row_strobe", 32'(row_strobe), 32'(e_row));
      check(col_drive == e_col, "R6 col_drive", 32'(col_drive), 32'(e_col));
      check(power_down == e_pd, "R10 power_down", 32'(power_down), 32'(e_pd));
      check(int'(ram_row) == m_pos / 64, "R2 ram_row", 32'(ram_row), 32'(m_pos / 64));
    end
  end

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); mux_tick = 1'b1;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); mux_tick = 1'b0;
      end
    end
    @(negedge clk); mux_tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; mux_tick = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  // Sets a level and counts how many cycles row 2 is lit over one frame.
  task automatic sweep(int lvl, bit red);
    int cnt = 0;
    int exp;
    @(negedge clk);
    level = 3'(lvl); peak_reduce = red; mux_tick = 1'b1;
    for (int i = 0; i < 448; i++) begin
      @(negedge clk);
      if (row_strobe[2]) cnt++;
    end
    mux_tick = 1'b0;
    exp = (ref_limit(lvl, red) > 0) ? ref_limit(lvl, red) - 1 : 0;
    check(cnt == exp, red ? "R9 lit slots reduced" : "R8 lit slots", 32'(cnt), 32'(exp));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 7; r++) mem[r] = 20'(32'h5A3C7 ^ (r * 32'h1F0B3));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(row_strobe == 0 && col_drive == 0, "R1 outputs in reset", 32'(row_strobe), 0);
    check(power_down == 0 && ram_row == 0, "R1 pd/row in reset", 32'({power_down, ram_row}), 0);
    @(negedge clk); rst_n = 1'b1; cmp_on = 1'b1;

    // R7: first advance shows slot 0 (dark); second shows slot 1 (lit, row 0)
    ticks(1, 0);
    check(row_strobe == 0, "R7 slot 0 dark", 32'(row_strobe), 0);
    ticks(1, 0);
    check(row_strobe == 7'h01, "R5 row 0 lit at slot 1", 32'(row_strobe), 1);
    check(col_drive == mem[0], "R6 row 0 columns", 32'(col_drive), 32'(mem[0]));
    ticks(62, 0);
    check(ram_row == 3'd1, "R2 row step after 64", 32'(ram_row), 1);
    ticks(384, 0);
    check(ram_row == 3'd0, "R2 frame wrap after 448", 32'(ram_row), 0);

    // R8 and R9: full-frame sweeps of every level in both peak modes
    for (int l = 0; l < 8; l++) sweep(l, 1'b0);
    for (int l = 0; l < 8; l++) sweep(l, 1'b1);
    peak_reduce = 1'b0;

    // R10: power-down flag follows level 7
    @(negedge clk); level = 3'd7;
    @(negedge clk);
    check(power_down == 1'b1, "R10 power_down set", 32'(power_down), 1);
    ticks(100, 0);
    check(row_strobe == 0 && col_drive == 0, "R10 blank", 32'(row_strobe), 0);
    @(negedge clk); level = 3'd1;
    @(negedge clk);
    check(power_down == 1'b0, "R10 power_down clear", 32'(power_down), 0);

    // R3: prescaled advance from a clean start
    do_reset();
    prescale_en = 1'b1; level = 3'd0;
    ticks(1023, 0);
    check(ram_row == 3'd0, "R3 before 1024 ticks", 32'(ram_row), 0);
    ticks(1, 0);
    check(ram_row == 3'd1, "R3 at 1024 ticks", 32'(ram_row), 1);

    // Irregular ticks, prescale off, data change mid-frame (R4, R6)
    prescale_en = 1'b0; level = 3'd2;
    ticks(300, 2);
    for (int r = 0; r < 7; r++) mem[r] = ~mem[r];
    ticks(500, 1);

    // R11: reset mid-scan
    ticks(77, 0);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check(ram_row == 0 && row_strobe == 0, "R11 async clear", 32'({ram_row, row_strobe}), 0);
    @(negedge clk); rst_n = 1'b1;
    ticks(2, 0);
    check(row_strobe == 7'h01, "R11 restart at row 0", 32'(row_strobe), 1);

    cmp_on = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule